// File: doc/BRIEF.md
# Delay-Line Phase Select Sequencer

This block moves a programmable delay line to a new sampling phase. A requester gives a phase index from 0 to 15 and pulses `start`. The sequencer then edits a 32-bit delay-line control word through a fixed handshake and drives that word straight out on `ctrl_word`.

The handshake runs in this order. The sequencer first takes the clock output down and puts clock recovery under external selection. It waits for the delay line's clock-output-enable status to read low. It then writes the phase as a Gray code and turns the clock output back on. It waits for the status to read high. Last, it hands phase selection back to clock recovery.

Each wait samples the status at a fixed spacing, measured in clock cycles and derived from the clock frequency. If a wait never sees the expected level, the sequencer gives up and reports a timeout. The block finishes by pulsing `done`, together with `err` when a wait timed out.

Top module: `dllph_seq`

## Requirements
- R1: While and after synchronous reset `busy`, `done` and `err` are 0, and `ctrl_word` equals the `RESET_WORD` parameter (default 32'h1200_00A5).
- R2: Two clock edges after `start` is accepted, `ctrl_word` has recovery enable (bit 17) and clock-output enable (bit 18) at 0, and external select (bit 19) and delay-line enable (bit 16) at 1.
- R3: The phase field `ctrl_word[23:20]` changes only while bit 18 is 0, and never before the status has been sampled at 0.
- R4: The phase field receives the Gray form of the index: 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8 for indices 0 to 15.
- R5: Bits 31:24 and 15:0 of `ctrl_word` always keep their reset value.
- R6: After the phase write, bit 18 is set and the sequencer waits for status 1. With a status that follows bit 18 at once, `done` is seen 7 cycles after `start`.
- R7: On success, bit 17 is set and bit 19 is cleared as the final step. `done` is then high for one cycle with `err` at 0 and `busy` at 0.
- R8: A status wait takes `MAX_POLLS` (50) samples. If none of them matches, the sequencer returns to idle and `done` and `err` are both high for exactly one cycle.
- R9: After a timeout, `ctrl_word` holds the value it had during the failed wait.
- R10: A `start` that arrives while `busy` is high is ignored. Its index never reaches the phase field, and it adds no extra `done`.
- R11: Successive status samples are `CLK_MHZ*POLL_US` cycles apart. With 4 cycles and the status stuck, a timeout in the first wait shows `done` 199 cycles after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to program a new phase |
| phase_idx | input | 4 | Requested phase index, binary 0 to 15 |
| ck_out_status | input | 1 | Clock-output-enable status from the delay line |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout flag, only together with `done` |
| ctrl_word | output | 32 | Delay-line control word |

## Verification
The assertions check on every cycle the parts of the protocol that depend only on the current and previous cycle:
- `done` is a single-cycle pulse and is never high while busy.
- `err` appears only with `done`.
- The bits outside the controlled fields never move.
- The phase field changes only while the clock output is off.
- A start while busy leaves the latched phase alone.
- The sample counter stays under its limit.

Other behaviour can only be shown by the bench's scenarios, which run a reference model alongside the design:
- the Gray mapping of every index;
- the exact latency for several status settling delays;
- timeouts in each of the two waits, with the control word frozen;
- a start request dropped in the middle of a sequence.

// File: rtl/dllph_pkg.sv
package dllph_pkg;

    localparam int WORD_W      = 32;
    localparam int PH_W        = 4;
    localparam int PH_LSB      = 20;
    localparam int DLL_EN_BIT  = 16;
    localparam int CDR_EN_BIT  = 17;
    localparam int CK_OUT_BIT  = 18;
    localparam int EXT_SEL_BIT = 19;

    // Bits the sequencer may touch: enables 16..19 plus phase field 20..23
    localparam logic [WORD_W-1:0] CTRL_MASK = 32'h00FF_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_WAIT_OFF,
        ST_WRITE_PH,
        ST_CK_ON,
        ST_WAIT_ON,
        ST_FINISH
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_PREP,
        OP_PHASE,
        OP_CK_ON,
        OP_FINISH
    } word_op_e;

    function automatic logic [PH_W-1:0] to_gray(input logic [PH_W-1:0] bin);
        return bin ^ (bin >> 1);
    endfunction

endpackage

// File: rtl/dllph_poll.sv
module dllph_poll
    import dllph_pkg::*;
#(
    parameter int GAP_CYCLES = 250,
    parameter int MAX_POLLS  = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic status,
    input  logic want,
    output logic hit,
    output logic expire
);
    localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES + 1) : 1;
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [GAP_W-1:0] gap_q;
    logic [CNT_W-1:0] polls_q;
    logic             sample;
    logic             match;
    logic             last;

    assign sample = active && (gap_q == '0);
    assign match  = (status == want);
    assign last   = (polls_q == CNT_W'(MAX_POLLS - 1));
    assign hit    = sample && match;
    assign expire = sample && !match && last;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            gap_q   <= '0;
            polls_q <= '0;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end else if (!match && !last) begin
            polls_q <= polls_q + 1'b1;
            gap_q   <= GAP_W'(GAP_CYCLES - 1);
        end
    end

    assert_poll_limit_R8: assert property (@(posedge clk) disable iff (rst)
        active |-> (polls_q < CNT_W'(MAX_POLLS)));

    assert_gap_bound_R11: assert property (@(posedge clk) disable iff (rst)
        gap_q <= GAP_W'(GAP_CYCLES - 1));

endmodule

// File: rtl/dllph_word.sv
module dllph_word
    import dllph_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_WORD = 32'h1200_00A5
) (
    input  logic              clk,
    input  logic              rst,
    input  word_op_e          op,
    input  logic [PH_W-1:0]   ph_code,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= RESET_WORD;
        end else begin
            case (op)
                OP_PREP: begin
                    word[CDR_EN_BIT]  <= 1'b0;
                    word[CK_OUT_BIT]  <= 1'b0;
                    word[EXT_SEL_BIT] <= 1'b1;
                    word[DLL_EN_BIT]  <= 1'b1;
                end
                OP_PHASE:  word[PH_LSB +: PH_W] <= ph_code;
                OP_CK_ON:  word[CK_OUT_BIT] <= 1'b1;
                OP_FINISH: begin
                    word[CDR_EN_BIT]  <= 1'b1;
                    word[EXT_SEL_BIT] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // The phase field may only move while the clock output is off
    assert_phase_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(word[PH_LSB +: PH_W]) |-> !word[CK_OUT_BIT]);

endmodule

// File: rtl/dllph_seq.sv
module dllph_seq
    import dllph_pkg::*;
#(
    parameter int                CLK_MHZ    = 250,
    parameter int                POLL_US    = 1,
    parameter int                MAX_POLLS  = 50,
    parameter logic [31:0]       RESET_WORD = 32'h1200_00A5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  phase_idx,
    input  logic        ck_out_status,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [31:0] ctrl_word
);
    localparam int GAP_CYCLES = CLK_MHZ * POLL_US;

    seq_state_e      state_q, state_d;
    word_op_e        op;
    logic [PH_W-1:0] ph_q;
    logic            done_q, err_q;
    logic            fin, tmo;
    logic            poll_active, poll_want, poll_hit, poll_expire;

    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign err         = err_q;
    assign poll_active = (state_q == ST_WAIT_OFF) || (state_q == ST_WAIT_ON);
    assign poll_want   = (state_q == ST_WAIT_ON);

    always_comb begin
        state_d = state_q;
        op      = OP_HOLD;
        fin     = 1'b0;
        tmo     = 1'b0;
        case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREP;
            ST_PREP: begin
                op      = OP_PREP;
                state_d = ST_WAIT_OFF;
            end
            ST_WAIT_OFF: begin
                if (poll_hit) begin
                    state_d = ST_WRITE_PH;
                end else if (poll_expire) begin
                    state_d = ST_IDLE;
                    tmo     = 1'b1;
                end
            end
            ST_WRITE_PH: begin
                op      = OP_PHASE;
                state_d = ST_CK_ON;
            end
            ST_CK_ON: begin
                op      = OP_CK_ON;
                state_d = ST_WAIT_ON;
            end
            ST_WAIT_ON: begin
                if (poll_hit) begin
                    state_d = ST_FINISH;
                end else if (poll_expire) begin
                    state_d = ST_IDLE;
                    tmo     = 1'b1;
                end
            end
            ST_FINISH: begin
                op      = OP_FINISH;
                state_d = ST_IDLE;
                fin     = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= fin | tmo;
            err_q   <= tmo;
            if (state_q == ST_IDLE && start) ph_q <= to_gray(phase_idx);
        end
    end

    dllph_poll #(
        .GAP_CYCLES (GAP_CYCLES),
        .MAX_POLLS  (MAX_POLLS)
    ) poll_i (
        .clk    (clk),
        .rst    (rst),
        .active (poll_active),
        .status (ck_out_status),
        .want   (poll_want),
        .hit    (poll_hit),
        .expire (poll_expire)
    );

    dllph_word #(
        .RESET_WORD (RESET_WORD)
    ) word_i (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .ph_code (ph_q),
        .word    (ctrl_word)
    );

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    assert_keep_other_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_word & ~CTRL_MASK) == (RESET_WORD & ~CTRL_MASK));

    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(ph_q));

endmodule

// File: tb/dllph_seq_tb_top.sv
`timescale 1ns/1ps
module dllph_seq_tb_top;

    localparam int          TB_MHZ = 4;
    localparam int          GAP    = 4;
    localparam int          POLLS  = 50;
    localparam logic [31:0] RST_W  = 32'h1200_00A5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  phase_idx = 4'd0;
    logic        ck_out_status = 1'b0;
    logic        busy, done, err;
    logic [31:0] ctrl_word;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit cmp_en = 1'b0;

    logic [3:0] gray_tab [16] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7, 4'h5, 4'h4,
                                  4'hC, 4'hD, 4'hF, 4'hE, 4'hA, 4'hB, 4'h9, 4'h8};

    always #2 clk = ~clk;

    dllph_seq #(
        .CLK_MHZ    (TB_MHZ),
        .POLL_US    (1),
        .MAX_POLLS  (POLLS),
        .RESET_WORD (RST_W)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .phase_idx     (phase_idx),
        .ck_out_status (ck_out_status),
        .busy          (busy),
        .done          (done),
        .err           (err),
        .ctrl_word     (ctrl_word)
    );

    // Status model: follows bit 18 after a settling lag, or is stuck
    int           st_mode = 0;   // 0 follow, 1 stuck high, 2 stuck low
    int           st_lag  = 0;
    logic [255:0] hist = '0;
    always @(negedge clk) begin
        hist <= {hist[254:0], ctrl_word[18]};
        if (st_mode == 1)      ck_out_status <= 1'b1;
        else if (st_mode == 2) ck_out_status <= 1'b0;
        else if (st_lag == 0)  ck_out_status <= ctrl_word[18];
        else                   ck_out_status <= hist[st_lag-1];
    end

    // Behavioural reference model
    int          m_step, m_gap, m_polls;
    logic [3:0]  m_ph;
    logic [31:0] m_word;
    logic        m_done, m_err;

    always @(posedge clk) begin
        if (rst) begin
            m_step <= 0; m_gap <= 0; m_polls <= 0; m_ph <= 4'd0;
            m_word <= RST_W; m_done <= 1'b0; m_err <= 1'b0;
        end else begin
            m_done <= 1'b0;
            m_err  <= 1'b0;
            if (m_step == 0) begin
                if (start) begin
                    m_ph   <= gray_tab[phase_idx];
                    m_step <= 1;
                end
            end else if (m_step == 1) begin
                m_word[17] <= 1'b0; m_word[18] <= 1'b0;
                m_word[19] <= 1'b1; m_word[16] <= 1'b1;
                m_step <= 2; m_gap <= 0; m_polls <= 0;
            end else if (m_step == 2 || m_step == 5) begin
                if (m_gap > 0) begin
                    m_gap <= m_gap - 1;
                end else if (ck_out_status == (m_step == 5)) begin
                    m_step <= m_step + 1; m_gap <= 0; m_polls <= 0;
                end else if (m_polls == POLLS - 1) begin
                    m_step <= 0; m_done <= 1'b1; m_err <= 1'b1;
                    m_polls <= 0; m_gap <= 0;
                end else begin
                    m_polls <= m_polls + 1; m_gap <= GAP - 1;
                end
            end else if (m_step == 3) begin
                m_word[23:20] <= m_ph; m_step <= 4;
            end else if (m_step == 4) begin
                m_word[18] <= 1'b1; m_step <= 5; m_gap <= 0; m_polls <= 0;
            end else begin
                m_word[17] <= 1'b1; m_word[19] <= 1'b0;
                m_step <= 0; m_done <= 1'b1;
            end
        end
    end

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare against the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            check_val("R10 busy vs model", {31'd0, busy}, {31'd0, m_step != 0});
            check_val("R7 done vs model",  {31'd0, done}, {31'd0, m_done});
            check_val("R8 err vs model",   {31'd0, err},  {31'd0, m_err});
            check_val("R4 word vs model",  ctrl_word, m_word);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Drive one request and count negedges until done is seen
    task automatic run_txn(input logic [3:0] idx, output int cycles);
        @(negedge clk);
        start     = 1'b1;
        phase_idx = idx;
        cycles    = 0;
        do begin
            @(negedge clk);
            cycles++;
            if (cycles == 1) start = 1'b0;
        end while (!done && cycles < 2000);
    endtask

    task automatic check_other(input string tag);
        check_val(tag, ctrl_word & 32'hFF00_FFFF, RST_W & 32'hFF00_FFFF);
    endtask

    initial begin
        int cyc_n;
        logic [3:0] prev_ph;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_val("R1 busy in reset", {31'd0, busy}, 32'd0);
        check_val("R1 word in reset", ctrl_word, RST_W);
        rst = 1'b0;
        @(negedge clk);
        cmp_en = 1'b1;
        check_val("R1 done after reset", {30'd0, done, err}, 32'd0);
        check_val("R1 word after reset", ctrl_word, RST_W);

        // R6: immediate status, fixed latency
        st_mode = 0; st_lag = 0;
        run_txn(4'd0, cyc_n);
        check_val("R6 latency", cyc_n, 7);
        check_val("R7 err on success", {31'd0, err}, 32'd0);

        // R4 / R7 / R5: every index, varying settle lag
        for (int i = 0; i < 16; i++) begin
            st_lag = i * 3;
            run_txn(i[3:0], cyc_n);
            check_val("R4 gray phase field", {28'd0, ctrl_word[23:20]}, {28'd0, gray_tab[i]});
            check_val("R7 final enables", {28'd0, ctrl_word[19:16]}, 32'h7);
            check_val("R7 no err", {31'd0, err}, 32'd0);
            check_other("R5 other bits");
        end

        // R2 / R3: prep state seen mid-sequence, phase not yet written
        st_lag  = 20;
        prev_ph = ctrl_word[23:20];
        @(negedge clk);
        start = 1'b1; phase_idx = 4'd9;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check_val("R2 prep enables", {28'd0, ctrl_word[19:16]}, 32'h9);
        check_val("R3 phase not yet written", {28'd0, ctrl_word[23:20]}, {28'd0, prev_ph});
        while (!done) @(negedge clk);
        check_val("R4 phase after slow settle", {28'd0, ctrl_word[23:20]}, {28'd0, gray_tab[9]});

        // R10: start while busy is dropped
        st_lag = 30;
        @(negedge clk);
        start = 1'b1; phase_idx = 4'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check_val("R10 busy mid-sequence", {31'd0, busy}, 32'd1);
        start = 1'b1; phase_idx = 4'd12;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check_val("R10 phase from first request", {28'd0, ctrl_word[23:20]}, {28'd0, gray_tab[3]});
        repeat (5) @(negedge clk);
        check_val("R10 no second sequence", {30'd0, busy, done}, 32'd0);

        // R8 / R9 / R11: timeout in the off wait (status stuck high)
        st_mode = 1;
        prev_ph = ctrl_word[23:20];
        run_txn(4'd6, cyc_n);
        check_val("R11 timeout latency", cyc_n, 199);
        check_val("R8 err with done", {30'd0, done, err}, 32'd3);
        check_val("R9 enables frozen", {28'd0, ctrl_word[19:16]}, 32'h9);
        check_val("R9 phase untouched", {28'd0, ctrl_word[23:20]}, {28'd0, prev_ph});
        @(negedge clk);
        check_val("R8 flags one cycle", {29'd0, busy, done, err}, 32'd0);

        // R8 / R9: timeout in the on wait (status stuck low)
        st_mode = 2;
        run_txn(4'd7, cyc_n);
        check_val("R8 second-wait timeout latency", cyc_n, 202);
        check_val("R8 err second wait", {31'd0, err}, 32'd1);
        check_val("R9 phase written then frozen", {28'd0, ctrl_word[23:20]}, {28'd0, gray_tab[7]});
        check_val("R9 ck on, recovery off", {28'd0, ctrl_word[19:16]}, 32'hD);
        check_other("R5 other bits after timeout");

        // R8: slow but in-window settling still succeeds
        st_mode = 0; st_lag = 150;
        run_txn(4'd13, cyc_n);
        check_val("R8 slow settle no err", {31'd0, err}, 32'd0);
        check_val("R4 slow settle phase", {28'd0, ctrl_word[23:20]}, {28'd0, gray_tab[13]});

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule